// File: doc/BRIEF.md
# Toggle-on-Write Interrupt Aggregator

This block collects the interrupt sources of a serial peripheral controller and folds them into one level-sensitive interrupt line. It holds three 32-bit registers: a pending-status register, a per-bit enable mask and a master gate register. The parent controller decodes its register bus down to a two-bit select, a write strobe and write data, and reads back through a combinational data port.

Single-cycle event pulses from the FIFO and transfer logic set their status bits. Two level conditions re-set their bits on every clock for as long as they hold. Software acknowledges by writing ones to the status register. Each written one inverts the stored bit instead of clearing it, so a driver must write back exactly the bits it saw set. The output line is registered. It is high when some enabled pending bit exists and the top bit of the gate register is one.

Top module: `spi_irq_toggle_agg`

## Requirements
- R1: After a synchronous active-low reset the status, enable and gate registers all read zero and `irq_o` is low.
- R2: A write with `reg_sel`=0 XORs `reg_wdata` into the status register; each written one inverts the stored bit and each zero leaves it unchanged.
- R3: A pulse on `xfer_done_i` sets status bit 2 (transmit empty) and bit 8 (receive not empty) together.
- R4: Pulses on `tx_empty_i`, `tx_underrun_i`, `rx_overrun_i` and `tx_half_i` set status bits 2, 3, 5 and 6 respectively; other bits are unchanged.
- R5: While `rx_nonempty_i` is high, status bit 8 is set on every clock, so a toggle write to bit 8 cannot clear it.
- R6: While `rx_full_i` is high, status bit 4 is set on every clock, so a toggle write to bit 4 cannot clear it.
- R7: When a set source and a toggle write hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_o` is a register: it is high in the cycle after one in which (status AND enable) is nonzero and gate bit 31 is one, and low otherwise.
- R9: `reg_sel`=1 writes the enable register and `reg_sel`=2 writes the gate register as plain storage; only bit 31 of the gate register affects `irq_o`.
- R10: Status bits with no source (0, 1, 7 and 9 to 31) act as plain storage under toggle writes.
- R11: `reg_sel`=3 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 gate, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| tx_empty_i | input | 1 | Pulse: transmit queue drained |
| tx_underrun_i | input | 1 | Pulse: transmit underrun |
| rx_overrun_i | input | 1 | Pulse: receive byte lost to a full queue |
| tx_half_i | input | 1 | Pulse: transmit queue half empty |
| xfer_done_i | input | 1 | Pulse: one byte exchange completed |
| rx_nonempty_i | input | 1 | Level: receive queue holds data |
| rx_full_i | input | 1 | Level: receive queue is full |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each source is pulsed alone against a clean status register, so a wrong bit position shows up as a mismatch at a single bit. Toggle writes are applied to set bits, to clear bits and to bits with no source. This separates XOR from write-one-to-clear and from plain overwrite. Level conditions are held while software tries to toggle their bits off, and a pulse is made to collide with a toggle of the same bit, which exposes wrong precedence. The gate register is loaded with every bit except 31 and then with bit 31 alone, which shows whether only the top bit gates the line.

// File: rtl/tia_pkg.sv
// Shared constants for the toggle-on-write interrupt aggregator.
// Assumes a 32-bit register bus; bit positions are fixed by software.
package tia_pkg;
    localparam int DATA_W      = 32;
    localparam int BIT_TX_EMPT = 2;
    localparam int BIT_TX_UNDR = 3;
    localparam int BIT_RX_FULL = 4;
    localparam int BIT_RX_OVR  = 5;
    localparam int BIT_TX_HALF = 6;
    localparam int BIT_RX_NEMP = 8;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_GATE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tia_status_reg.sv
// Pending-status register. Each bit is XOR-toggled by a write and
// then OR-ed with its set request, so a set wins over a toggle.
// Assumes set_i is already aligned to status bit positions.
module tia_status_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tgl_en_i,
    input  logic [W-1:0] tgl_val_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic bit_q;
        // Per-bit update: reset, toggle, then set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else
                bit_q <= (tgl_en_i ? (bit_q ^ tgl_val_i[b]) : bit_q) | set_i[b];
        end
        assign q_o[b] = bit_q;
    end
endmodule

// File: rtl/tia_plain_reg.sv
// Plain storage register written whole when its strobe is high.
// Assumes a synchronous active-low reset to zero.
module tia_plain_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/tia_irq_out.sv
// Registered interrupt line: high when any enabled status bit is
// pending and the gate bit is one. Assumes one cycle of latency is fine.
module tia_irq_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] enable_i,
    input  logic         gate_i,
    output logic         irq_o
);
    logic any_pend;
    // Reduce the masked status to one bit.
    always_comb any_pend = |(status_i & enable_i);

    // Register the gated request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= any_pend & gate_i;
    end
endmodule

// File: rtl/spi_irq_toggle_agg.sv
// Interrupt aggregator for a serial controller: status with toggle
// writes and set sources, an enable mask, a gate register whose top
// bit qualifies the registered interrupt line. Assumes the parent has
// decoded the bus to reg_sel/reg_wr and that event inputs are pulses.
module spi_irq_toggle_agg
    import tia_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   reg_sel,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         tx_empty_i,
    input  logic         tx_underrun_i,
    input  logic         rx_overrun_i,
    input  logic         tx_half_i,
    input  logic         xfer_done_i,
    input  logic         rx_nonempty_i,
    input  logic         rx_full_i,
    output logic         irq_o
);
    localparam int GATE_BIT = W - 1;

    logic [W-1:0] set_vec;
    logic [W-1:0] st_q, en_q, gate_q;
    logic         wr_st, wr_en, wr_gate;

    // Map sources onto their status bit positions.
    always_comb begin
        set_vec              = '0;
        set_vec[BIT_TX_EMPT] = tx_empty_i | xfer_done_i;
        set_vec[BIT_TX_UNDR] = tx_underrun_i;
        set_vec[BIT_RX_FULL] = rx_full_i;
        set_vec[BIT_RX_OVR]  = rx_overrun_i;
        set_vec[BIT_TX_HALF] = tx_half_i;
        set_vec[BIT_RX_NEMP] = rx_nonempty_i | xfer_done_i;
    end

    // Decode write strobes per register.
    always_comb begin
        wr_st   = reg_wr && (reg_sel == SEL_STATUS);
        wr_en   = reg_wr && (reg_sel == SEL_ENABLE);
        wr_gate = reg_wr && (reg_sel == SEL_GATE);
    end

    tia_status_reg #(.W(W)) u_status (
        .clk(clk), .rst_n(rst_n), .tgl_en_i(wr_st), .tgl_val_i(reg_wdata),
        .set_i(set_vec), .q_o(st_q)
    );

    tia_plain_reg #(.W(W)) u_enable (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en), .d_i(reg_wdata), .q_o(en_q)
    );

    tia_plain_reg #(.W(W)) u_gate (
        .clk(clk), .rst_n(rst_n), .we_i(wr_gate), .d_i(reg_wdata), .q_o(gate_q)
    );

    tia_irq_out #(.W(W)) u_irq (
        .clk(clk), .rst_n(rst_n), .status_i(st_q), .enable_i(en_q),
        .gate_i(gate_q[GATE_BIT]), .irq_o(irq_o)
    );

    // Read multiplexer; unused select reads zero.
    always_comb begin
        unique case (reg_sel)
            SEL_STATUS: reg_rdata = st_q;
            SEL_ENABLE: reg_rdata = en_q;
            SEL_GATE:   reg_rdata = gate_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tia_checker.sv
// Property checker for spi_irq_toggle_agg, attached with bind.
module tia_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   reg_sel,
    input logic         reg_wr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] st_q,
    input logic [W-1:0] en_q,
    input logic [W-1:0] gate_q,
    input logic         tx_empty_i,
    input logic         tx_underrun_i,
    input logic         rx_overrun_i,
    input logic         tx_half_i,
    input logic         xfer_done_i,
    input logic         rx_nonempty_i,
    input logic         rx_full_i,
    input logic         irq_o
);
    logic quiet;
    always_comb quiet = !(tx_empty_i | tx_underrun_i | rx_overrun_i |
                          tx_half_i | xfer_done_i | rx_nonempty_i | rx_full_i);

    // R2
    toggle_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && quiet) |=> st_q == ($past(st_q) ^ $past(reg_wdata)));
    // R3
    xfer_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_i |=> (st_q[2] && st_q[8]));
    // R5
    nonempty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nonempty_i |=> st_q[8]);
    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_i |=> st_q[4]);
    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q[W-1] |=> !irq_o);
    // R8
    none_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & en_q) == '0) |=> !irq_o);
    // R11
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd3 && quiet) |=>
            ($stable(st_q) && $stable(en_q) && $stable(gate_q)));
endmodule

bind spi_irq_toggle_agg tia_checker #(.W(W)) u_tia_checker (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .st_q(st_q), .en_q(en_q), .gate_q(gate_q),
    .tx_empty_i(tx_empty_i), .tx_underrun_i(tx_underrun_i),
    .rx_overrun_i(rx_overrun_i), .tx_half_i(tx_half_i),
    .xfer_done_i(xfer_done_i), .rx_nonempty_i(rx_nonempty_i),
    .rx_full_i(rx_full_i), .irq_o(irq_o)
);

// File: tb/test_spi_irq_toggle_agg.sv
module test_spi_irq_toggle_agg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_empty_i = 0, tx_underrun_i = 0, rx_overrun_i = 0, tx_half_i = 0;
    logic        xfer_done_i = 0, rx_nonempty_i = 0, rx_full_i = 0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // behavioural reference state
    int unsigned m_st = 0, m_en = 0, m_gate = 0;
    bit          m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_toggle_agg i_spi_irq_toggle_agg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_empty_i(tx_empty_i), .tx_underrun_i(tx_underrun_i),
        .rx_overrun_i(rx_overrun_i), .tx_half_i(tx_half_i),
        .xfer_done_i(xfer_done_i), .rx_nonempty_i(rx_nonempty_i),
        .rx_full_i(rx_full_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what,
                         input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // ev bits: 0 tx_empty,1 underrun,2 overrun,3 half,4 xfer,5 nonempty,6 full
    task automatic step(input bit rst, input logic [1:0] sel, input bit wr,
                        input logic [31:0] wd, input logic [6:0] ev, input string req);
        int unsigned set_m, n_st, n_en, n_gate;
        bit n_irq;
        rst_n = ~rst; reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        tx_empty_i = ev[0]; tx_underrun_i = ev[1]; rx_overrun_i = ev[2];
        tx_half_i = ev[3]; xfer_done_i = ev[4]; rx_nonempty_i = ev[5]; rx_full_i = ev[6];
        set_m = 0;
        if (ev[0] || ev[4]) set_m |= 32'h4;
        if (ev[1]) set_m |= 32'h8;
        if (ev[6]) set_m |= 32'h10;
        if (ev[2]) set_m |= 32'h20;
        if (ev[3]) set_m |= 32'h40;
        if (ev[5] || ev[4]) set_m |= 32'h100;
        n_st   = ((wr && sel == 0) ? (m_st ^ wd) : m_st) | set_m;
        n_en   = (wr && sel == 1) ? wd : m_en;
        n_gate = (wr && sel == 2) ? wd : m_gate;
        n_irq  = ((m_st & m_en) != 0) && m_gate[31];
        if (rst) begin n_st = 0; n_en = 0; n_gate = 0; n_irq = 0; end
        @(posedge clk);
        #1;
        m_st = n_st; m_en = n_en; m_gate = n_gate; m_irq = n_irq;
        check(req, "irq_o", irq_o, m_irq);
        case (sel)
            2'd0: check(req, "status", reg_rdata, m_st);
            2'd1: check(req, "enable", reg_rdata, m_en);
            2'd2: check(req, "gate", reg_rdata, m_gate);
            default: check(req, "unused", reg_rdata, 0);
        endcase
    endtask

    task automatic rd(input logic [1:0] sel, input string req);
        step(0, sel, 0, '0, '0, req);
    endtask

    initial begin
        // R1: reset state on every register
        step(1, 0, 0, '0, '0, "R1");
        step(1, 0, 0, '0, '0, "R1");
        rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(3, "R1");
        // R9: enable and gate storage; gate without bit 31
        step(0, 1, 1, 32'hFFFF_FFFF, '0, "R9"); rd(1, "R9");
        step(0, 2, 1, 32'h7FFF_FFFF, '0, "R9"); rd(2, "R9");
        // R10: sourceless bits toggle like storage, irq stays low (gate bit 31 off)
        step(0, 0, 1, 32'h8001_0083, '0, "R10"); rd(0, "R9"); rd(0, "R9");
        // R8: open the gate, irq follows one cycle later
        step(0, 2, 1, 32'h8000_0000, '0, "R8"); rd(0, "R8"); rd(0, "R8");
        // R2: toggle half of them back
        step(0, 0, 1, 32'h8000_0003, '0, "R2"); rd(0, "R2");
        step(0, 0, 1, 32'h0001_0080, '0, "R2"); rd(0, "R8"); rd(0, "R8");
        // R4: individual pulses, each cleared with a toggle
        step(0, 0, 0, '0, 7'b000_0001, "R4"); step(0, 0, 1, 32'h4, '0, "R4");
        step(0, 0, 0, '0, 7'b000_0010, "R4"); step(0, 0, 1, 32'h8, '0, "R4");
        step(0, 0, 0, '0, 7'b000_0100, "R4"); step(0, 0, 1, 32'h20, '0, "R4");
        step(0, 0, 0, '0, 7'b000_1000, "R4"); step(0, 0, 1, 32'h40, '0, "R4");
        rd(0, "R4");
        // R3: byte exchange completion
        step(0, 0, 0, '0, 7'b001_0000, "R3"); rd(0, "R3");
        step(0, 0, 1, 32'h104, '0, "R3"); rd(0, "R3");
        // R5: held non-empty level defeats a toggle
        step(0, 0, 0, '0, 7'b010_0000, "R5");
        step(0, 0, 1, 32'h100, 7'b010_0000, "R5");
        step(0, 0, 0, '0, 7'b010_0000, "R5");
        step(0, 0, 1, 32'h100, '0, "R5"); rd(0, "R5");
        // R6: held full level defeats a toggle
        step(0, 0, 0, '0, 7'b100_0000, "R6");
        step(0, 0, 1, 32'h10, 7'b100_0000, "R6");
        step(0, 0, 1, 32'h10, '0, "R6"); rd(0, "R6");
        // R7: pulse collides with a toggle of the same set bit
        step(0, 0, 0, '0, 7'b000_0010, "R7");
        step(0, 0, 1, 32'h8, 7'b000_0010, "R7");
        step(0, 0, 1, 32'h8, '0, "R7"); rd(0, "R7");
        // R11: unused select ignores writes and reads zero
        step(0, 3, 1, 32'hFFFF_FFFF, '0, "R11"); rd(3, "R11");
        rd(0, "R11"); rd(1, "R11"); rd(2, "R11");
        // R1: reset again from a loaded state
        step(0, 0, 1, 32'h1, '0, "R1"); rd(0, "R1");
        step(1, 0, 0, '0, '0, "R1"); rd(1, "R1"); rd(2, "R1");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule